// File: doc/BRIEF.md
# Banked Memory Address Mapper

This block sits between a processor's address generator and its memories. It takes a 12-bit logical word address with read and write strobes and decides what the access reaches. The options are a word of writable RAM, a word of read-only ROM, one of the eight core register locations at the bottom of the space, or one of four editing locations. For RAM and ROM it forms the physical word address. Part of the logical space is a fixed view of certain banks. The rest is a switchable window whose bank comes from a bank register.

The block holds the RAM bank register (3 bits), the ROM bank register (5 bits) and the four editing registers. A combined bank location reads and writes both bank registers in one word. A superbank enable input remaps the top eight ROM bank numbers onto eight further banks, which gives 40 ROM banks. The zero location reads as zero and drops writes. Each editing location returns its stored word rotated or shifted when it is read.

Address mapping and read data are purely combinational. Register writes take effect at the next rising clock edge. The memory arrays and the core registers (accumulator, second accumulator, link, program counter) are held outside the block. For those, the block only raises the matching select line.

Top module: `bankMapper`

## Requirements
- R1: An access is active when rdEn or wrEn is high. ramSel is high for an active access with logAddr[11:10]=00, except locations 0x000-0x007 and 0x010-0x013. romSel is high only when rdEn is high and logAddr[11:10] is not 00. regSel bit n is high for an active access to location n (0..7). Otherwise these lines are low. At most one of them is high at any time.
- R2: For a RAM access at 0x008-0x2FF (excluding 0x010-0x013), ramAddr equals logAddr[9:0]. This means bank logAddr[9:8] with offset logAddr[7:0].
- R3: For a RAM access at 0x300-0x3FF, ramAddr equals RAM bank register × 256 + logAddr[7:0].
- R4: For a ROM read at 0x800-0xFFF, romAddr equals 2048 + logAddr[10:0], which is fixed banks 2 and 3.
- R5: For a ROM read at 0x400-0x7FF with superEn low, romAddr equals ROM bank register × 1024 + logAddr[9:0].
- R6: With superEn high and a ROM bank register value of 24-31, a read at 0x400-0x7FF uses bank (value + 8), giving banks 32-39. Values 0-23 are unaffected.
- R7: A write to location 3 loads the RAM bank register from wrData[2:0]. A write to location 4 loads the ROM bank register from wrData[14:10]. A write to location 6 loads both from those same fields. Each write takes effect at the next clock edge. Reads return {12'b0, ram bank} at location 3, {rom bank, 10'b0} at location 4, and {rom bank, 7'b0, ram bank} at location 6.
- R8: Location 7 reads as zero, and a write to it changes no register.
- R9: Location 0x010 stores a written word v and reads back v rotated right by one: {v[0], v[14:1]}.
- R10: Location 0x011 reads back v shifted right by one with zero fill.
- R11: Location 0x012 reads back v rotated left by one: {v[13:0], v[14]}.
- R12: Location 0x013 reads back v shifted right by seven with zero fill.
- R13: rdData is zero when rdEn is low. It is also zero for any location the block does not hold (RAM, ROM, locations 0, 1, 2, 5, 7).
- R14: Reset clears both bank registers and all four editing registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| logAddr | input | 12 | Logical word address |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 15 | Write data |
| superEn | input | 1 | Superbank enable |
| ramSel | output | 1 | Access targets RAM |
| ramAddr | output | 11 | Physical RAM word address, valid while ramSel |
| romSel | output | 1 | Read targets ROM |
| romAddr | output | 16 | Physical ROM word address, valid while romSel |
| regSel | output | 8 | One-hot select of core register locations 0-7 |
| rdData | output | 15 | Read data from block-held locations |

## Verification
The embedded properties check these rules on every cycle:
- The selects are mutually exclusive.
- ROM is never selected without a read.
- A write strobe loads exactly the bank register it names.
- A bank or editing register never changes without its strobe.
- The physical ROM bank number always stays below 40.

Only the bench's scenarios can show that the address arithmetic is correct for each window. The same applies to the exact superbank threshold at 23/24 and to the rotate and shift results of each editing location. The bench shows these by comparing every output against a behavioural model on every applied vector.

// File: rtl/bankMapPkg.sv
package bankMapPkg;
  localparam int ADDR_W    = 12;
  localparam int RAM_OFF_W = 8;
  localparam int ROM_OFF_W = 10;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_EB   = 3'd1,
    SRC_FB   = 3'd2,
    SRC_BB   = 3'd3,
    SRC_EDIT = 3'd4
  } rdSrcT;

  typedef struct packed {
    logic       wrEb;
    logic       wrFb;
    logic [3:0] wrEdit;
    rdSrcT      rdSrc;
    logic [1:0] editIdx;
    logic       ramBanked;
    logic       romBanked;
  } ctrlStrobeT;
endpackage

// File: rtl/bankCtrl.sv
module bankCtrl
  import bankMapPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] logAddr,
  input  logic              rdEn,
  input  logic              wrEn,
  output ctrlStrobeT        st,
  output logic              ramSel,
  output logic              romSel,
  output logic [7:0]        regSel
);
  logic active, isLow, isCore, isEdit;

  always_comb begin
    active = rdEn | wrEn;
    isLow  = (logAddr[ADDR_W-1 -: 2] == 2'b00);
    isCore = (logAddr[ADDR_W-1:3] == '0);
    isEdit = (logAddr[ADDR_W-1:2] == (ADDR_W-2)'(4));
  end

  always_comb begin
    ramSel = active && isLow && !isCore && !isEdit;
    romSel = rdEn && !isLow;
    regSel = (active && isCore) ? (8'b1 << logAddr[2:0]) : 8'b0;
  end

  always_comb begin
    st            = '0;
    st.wrEb       = wrEn && isCore && (logAddr[2:0] == 3'd3 || logAddr[2:0] == 3'd6);
    st.wrFb       = wrEn && isCore && (logAddr[2:0] == 3'd4 || logAddr[2:0] == 3'd6);
    st.wrEdit     = (wrEn && isEdit) ? (4'b1 << logAddr[1:0]) : 4'b0;
    st.editIdx    = logAddr[1:0];
    st.ramBanked  = (logAddr[RAM_OFF_W+1:RAM_OFF_W] == 2'b11);
    st.romBanked  = !logAddr[ADDR_W-1];
    st.rdSrc      = SRC_NONE;
    if (rdEn && isCore) begin
      case (logAddr[2:0])
        3'd3:    st.rdSrc = SRC_EB;
        3'd4:    st.rdSrc = SRC_FB;
        3'd6:    st.rdSrc = SRC_BB;
        default: st.rdSrc = SRC_NONE;
      endcase
    end else if (rdEn && isEdit) begin
      st.rdSrc = SRC_EDIT;
    end
  end

  // R1: selects never overlap
  p_sel_exclusive_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ramSel, romSel, (regSel != 8'b0)}));

  // R1: ROM is read-only
  p_rom_read_only_r1: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> !romSel);

  // R13: nothing selected without a strobe
  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn || wrEn) |-> (!ramSel && !romSel && regSel == 8'b0));
endmodule

// File: rtl/bankDatapath.sv
module bankDatapath
  import bankMapPkg::*;
#(
  parameter int WORD_W      = 15,
  parameter int EB_W        = 3,
  parameter int FB_W        = 5,
  parameter int SUPER_BANKS = 8,
  localparam int RAM_ADDR_W = EB_W + RAM_OFF_W,
  localparam int ROM_BANKS  = (1 << FB_W) + SUPER_BANKS,
  localparam int ROM_BANK_W = $clog2(ROM_BANKS),
  localparam int ROM_ADDR_W = ROM_BANK_W + ROM_OFF_W
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobeT            st,
  input  logic [ROM_OFF_W:0]    offIn,
  input  logic [WORD_W-1:0]     wrData,
  input  logic                  superEn,
  output logic [RAM_ADDR_W-1:0] ramAddr,
  output logic [ROM_ADDR_W-1:0] romAddr,
  output logic [WORD_W-1:0]     rdData
);
  localparam int SUPER_BASE    = (1 << FB_W) - SUPER_BANKS;
  localparam int FIXED_ROM_BASE = 2;
  localparam int SHIFT_FAR     = 7;

  logic [EB_W-1:0]               ebQ;
  logic [FB_W-1:0]               fbQ;
  logic [3:0][WORD_W-1:0]        editQ;
  logic [EB_W-1:0]               ramBank;
  logic [ROM_BANK_W-1:0]         romBank;
  logic [WORD_W-1:0]             editVal, editOut;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ebQ <= '0;
      fbQ <= '0;
    end else begin
      if (st.wrEb) ebQ <= wrData[EB_W-1:0];
      if (st.wrFb) fbQ <= wrData[WORD_W-1 -: FB_W];
    end
  end

  for (genvar g = 0; g < 4; g++) begin : gEdit
    always_ff @(posedge clk) begin
      if (!rstN)            editQ[g] <= '0;
      else if (st.wrEdit[g]) editQ[g] <= wrData;
    end
  end

  always_comb begin
    editVal = editQ[st.editIdx];
    case (st.editIdx)
      2'd0:    editOut = {editVal[0], editVal[WORD_W-1:1]};
      2'd1:    editOut = {1'b0, editVal[WORD_W-1:1]};
      2'd2:    editOut = {editVal[WORD_W-2:0], editVal[WORD_W-1]};
      default: editOut = {{SHIFT_FAR{1'b0}}, editVal[WORD_W-1:SHIFT_FAR]};
    endcase
  end

  always_comb begin
    ramBank = st.ramBanked ? ebQ : EB_W'(offIn[RAM_OFF_W+1:RAM_OFF_W]);
    ramAddr = {ramBank, offIn[RAM_OFF_W-1:0]};
  end

  always_comb begin
    if (st.romBanked) begin
      if (superEn && fbQ >= FB_W'(SUPER_BASE))
        romBank = ROM_BANK_W'(fbQ) + ROM_BANK_W'(SUPER_BANKS);
      else
        romBank = ROM_BANK_W'(fbQ);
    end else begin
      romBank = ROM_BANK_W'(FIXED_ROM_BASE) + ROM_BANK_W'(offIn[ROM_OFF_W]);
    end
    romAddr = {romBank, offIn[ROM_OFF_W-1:0]};
  end

  always_comb begin
    case (st.rdSrc)
      SRC_EB:   rdData = WORD_W'(ebQ);
      SRC_FB:   rdData = {fbQ, {(WORD_W-FB_W){1'b0}}};
      SRC_BB:   rdData = {fbQ, {(WORD_W-FB_W-EB_W){1'b0}}, ebQ};
      SRC_EDIT: rdData = editOut;
      default:  rdData = '0;
    endcase
  end

  // R7: bank register loads the named field one edge later
  p_eb_update_r7: assert property (@(posedge clk) disable iff (!rstN)
    st.wrEb |=> ebQ == $past(wrData[EB_W-1:0]));
  p_fb_update_r7: assert property (@(posedge clk) disable iff (!rstN)
    st.wrFb |=> fbQ == $past(wrData[WORD_W-1 -: FB_W]));

  // R8: no strobe, no change (covers zero-location writes)
  p_bank_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(st.wrEb || st.wrFb) |=> ($stable(ebQ) && $stable(fbQ)));

  // R9: editing registers only change on their strobe
  p_edit_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrEdit == 4'b0) |=> $stable(editQ));

  // R6: physical ROM bank stays inside the populated range
  p_rom_bank_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    romAddr[ROM_ADDR_W-1:ROM_OFF_W] < ROM_BANK_W'(ROM_BANKS));
endmodule

// File: rtl/bankMapper.sv
module bankMapper
  import bankMapPkg::*;
#(
  parameter int WORD_W      = 15,
  parameter int EB_W        = 3,
  parameter int FB_W        = 5,
  parameter int SUPER_BANKS = 8,
  localparam int RAM_ADDR_W = EB_W + RAM_OFF_W,
  localparam int ROM_BANK_W = $clog2((1 << FB_W) + SUPER_BANKS),
  localparam int ROM_ADDR_W = ROM_BANK_W + ROM_OFF_W
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     logAddr,
  input  logic                  rdEn,
  input  logic                  wrEn,
  input  logic [WORD_W-1:0]     wrData,
  input  logic                  superEn,
  output logic                  ramSel,
  output logic [RAM_ADDR_W-1:0] ramAddr,
  output logic                  romSel,
  output logic [ROM_ADDR_W-1:0] romAddr,
  output logic [7:0]            regSel,
  output logic [WORD_W-1:0]     rdData
);
  ctrlStrobeT st;

  bankCtrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .logAddr (logAddr),
    .rdEn    (rdEn),
    .wrEn    (wrEn),
    .st      (st),
    .ramSel  (ramSel),
    .romSel  (romSel),
    .regSel  (regSel)
  );

  bankDatapath #(
    .WORD_W      (WORD_W),
    .EB_W        (EB_W),
    .FB_W        (FB_W),
    .SUPER_BANKS (SUPER_BANKS)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .st      (st),
    .offIn   (logAddr[ROM_OFF_W:0]),
    .wrData  (wrData),
    .superEn (superEn),
    .ramAddr (ramAddr),
    .romAddr (romAddr),
    .rdData  (rdData)
  );
endmodule

// File: tb/sim_bankMapper.sv
module sim_bankMapper;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] logAddr = '0;
  logic        rdEn = 1'b0, wrEn = 1'b0, superEn = 1'b0;
  logic [14:0] wrData = '0;
  logic        ramSel, romSel;
  logic [10:0] ramAddr;
  logic [15:0] romAddr;
  logic [7:0]  regSel;
  logic [14:0] rdData;

  int vecs = 0, bad = 0;
  bit done = 0;
  // behavioural state
  int mEb = 0, mFb = 0;
  int mEd [4] = '{0, 0, 0, 0};

  always #10 clk = ~clk;

  bankMapper u0 (
    .clk(clk), .rstN(rstN), .logAddr(logAddr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .superEn(superEn), .ramSel(ramSel), .ramAddr(ramAddr),
    .romSel(romSel), .romAddr(romAddr), .regSel(regSel), .rdData(rdData));

  function automatic string tagOf(int a, bit rd, bit sup);
    if (!rd && a >= 8'h03 && a <= 8'h13) return "R13";
    if (a < 8) begin
      if (a == 3 || a == 4 || a == 6) return "R7";
      if (a == 7) return "R8";
      return "R1";
    end
    if (a == 'h10) return "R9";
    if (a == 'h11) return "R10";
    if (a == 'h12) return "R11";
    if (a == 'h13) return "R12";
    if (a < 'h300) return "R2";
    if (a < 'h400) return "R3";
    if (a < 'h800) return sup ? "R6" : "R5";
    return "R4";
  endfunction

  function automatic int readVal(int a);
    int v;
    case (a)
      3: return mEb;
      4: return mFb << 10;
      6: return (mFb << 10) | mEb;
      'h10: begin v = mEd[0]; return ((v & 1) << 14) | (v >> 1); end
      'h11: begin v = mEd[1]; return v >> 1; end
      'h12: begin v = mEd[2]; return ((v << 1) & 'h7FFF) | (v >> 14); end
      'h13: begin v = mEd[3]; return v >> 7; end
      default: return 0;
    endcase
  endfunction

  task automatic apply(input int a, input bit rd, input bit wr, input int d,
                       input bit sup, input string tagIn);
    bit act, eRam, eRom, core, edit;
    int eRamA, eRomA, eData, eReg, fb;
    string tag;
    @(negedge clk);
    logAddr = 12'(a); rdEn = rd; wrEn = wr; wrData = 15'(d); superEn = sup;
    #2;
    tag  = (tagIn == "") ? tagOf(a, rd, sup) : tagIn;
    act  = rd | wr;
    core = (a < 8);
    edit = (a >= 'h10 && a <= 'h13);
    eRam = act && (a < 'h400) && !core && !edit;
    eRom = rd && (a >= 'h400);
    eReg = (act && core) ? (1 << a) : 0;
    eData = rd ? readVal(a) : 0;
    eRamA = (a >= 'h300) ? (mEb * 256 + (a & 'hFF)) : (a & 'h3FF);
    fb = (sup && mFb >= 24) ? mFb + 8 : mFb;
    eRomA = (a >= 'h800) ? (2048 + (a & 'h7FF)) : (fb * 1024 + (a & 'h3FF));
    vecs++;
    if (ramSel !== eRam || romSel !== eRom || regSel !== 8'(eReg) ||
        rdData !== 15'(eData) || (eRam && ramAddr !== 11'(eRamA)) ||
        (eRom && romAddr !== 16'(eRomA))) begin
      bad++;
      $display("FAIL %s addr=%h: got ram=%b/%h rom=%b/%h reg=%h data=%h exp ram=%b/%h rom=%b/%h reg=%h data=%h",
               tag, a, ramSel, ramAddr, romSel, romAddr, regSel, rdData,
               eRam, 11'(eRamA), eRom, 16'(eRomA), 8'(eReg), 15'(eData));
    end
    @(posedge clk);
    if (wr) begin
      if (a == 3 || a == 6) mEb = d & 7;
      if (a == 4 || a == 6) mFb = (d >> 10) & 'h1F;
      if (edit) mEd[a - 'h10] = d & 'h7FFF;
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // R14: reset state
    apply(3, 1, 0, 0, 0, "R14");
    apply(4, 1, 0, 0, 0, "R14");
    apply(6, 1, 0, 0, 0, "R14");
    for (int i = 'h10; i <= 'h13; i++) apply(i, 1, 0, 0, 0, "R14");
    // R1: core register selects
    for (int i = 0; i < 8; i++) apply(i, 1, 0, 0, 0, "R1");
    apply(5, 0, 1, 'h1234, 0, "R1");
    // R7 / R3: RAM bank register and window
    apply(3, 0, 1, 'h7FFD, 0, "R7");
    apply(3, 1, 0, 0, 0, "R7");
    apply('h3A5, 1, 0, 0, 0, "R3");
    apply('h300, 0, 1, 'h55, 0, "R3");
    apply('h3FF, 1, 0, 0, 0, "R3");
    // R7 / R5: ROM bank register and window
    apply(4, 0, 1, 17 << 10 | 'h3FF, 0, "R7");
    apply(4, 1, 0, 0, 0, "R7");
    apply('h512, 1, 0, 0, 0, "R5");
    apply('h7FF, 1, 0, 0, 1, "R5");
    // R7: combined bank location
    apply(6, 0, 1, (26 << 10) | 2, 0, "R7");
    apply(6, 1, 0, 0, 0, "R7");
    apply(3, 1, 0, 0, 0, "R7");
    apply('h4AB, 1, 0, 0, 0, "R5");
    // R6: superbank threshold
    apply('h4AB, 1, 0, 0, 1, "R6");
    apply(4, 0, 1, 23 << 10, 0, "R7");
    apply('h400, 1, 0, 0, 1, "R6");
    apply(4, 0, 1, 24 << 10, 0, "R7");
    apply('h400, 1, 0, 0, 1, "R6");
    apply(4, 0, 1, 31 << 10, 0, "R7");
    apply('h7FF, 1, 0, 0, 1, "R6");
    // R2: fixed RAM
    apply('h008, 1, 0, 0, 0, "R2");
    apply('h014, 1, 0, 0, 0, "R2");
    apply('h1FF, 0, 1, 9, 0, "R2");
    apply('h2FF, 1, 0, 0, 0, "R2");
    // R4: fixed ROM
    apply('h800, 1, 0, 0, 0, "R4");
    apply('hC37, 1, 0, 0, 1, "R4");
    apply('hFFF, 1, 0, 0, 0, "R4");
    // R8: zero location
    apply(7, 0, 1, 'h7FFF, 0, "R8");
    apply(7, 1, 0, 0, 0, "R8");
    apply(6, 1, 0, 0, 0, "R8");
    // R9..R12: editing locations
    apply('h10, 0, 1, 'h4001, 0, "R9");
    apply('h10, 1, 0, 0, 0, "R9");
    apply('h11, 0, 1, 'h7FFF, 0, "R10");
    apply('h11, 1, 0, 0, 0, "R10");
    apply('h12, 0, 1, 'h4002, 0, "R11");
    apply('h12, 1, 0, 0, 0, "R11");
    apply('h13, 0, 1, 'h7F80, 0, "R12");
    apply('h13, 1, 0, 0, 0, "R12");
    // R13: read gating and ROM write ignored
    apply('h10, 0, 0, 0, 0, "R13");
    apply(6, 0, 0, 0, 0, "R13");
    apply('h900, 0, 1, 'h1111, 0, "R13");
    apply('h3A0, 0, 0, 0, 0, "R13");
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      int a;
      a = (i % 4 == 0) ? ($urandom % 'h18) : ($urandom % 4096);
      apply(a, 1'($urandom), 1'($urandom), $urandom % 32768, 1'($urandom), "");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule